// File: doc/BRIEF.md
# Chainable Resource-Driven Event Counter

This block is a 16-bit down-counter for a trace or debug event unit. A programmable control word picks one event source that makes the counter count down, and a second event source that reloads it from a stored reload value. Each source can be one of sixteen single resource lines or one of eight combined resource-pair lines. The combining logic that forms the pairs is outside the block.

Two options widen its use. With self-reload set, the counter reloads when it sits at zero and its count source fires again. With chaining set, the counter also counts down on each reload pulse from a neighbouring lower counter. The counter's own one-cycle reload pulse can feed the next counter up, so that two instances act as one wider counter.

A small FSM tracks whether the counter is live (`ST_ACTIVE`) or drained (`ST_EXPIRED`). The transition *drain* (`ST_ACTIVE` to `ST_EXPIRED`) happens when the next count is zero, whether that comes from a decrement, a reload of zero or a write of zero. The transition *rearm* (`ST_EXPIRED` to `ST_ACTIVE`) happens when a reload or a write gives a non-zero count. In every other case the FSM holds its state. Reset enters `ST_EXPIRED`.

Top module: `event_down_counter`

## Requirements
- R1: After reset the count, the control word and the reload value are all zero, `at_zero` is 1 and `reload_pulse` is 0.
- R2: A write with `wr_en`=1 goes to the register chosen by `wr_sel`: 0 selects the control word, 1 selects the reload value (`wr_data[15:0]`), 2 selects the count, and 3 changes nothing. A count write appears on `count` one cycle later and takes precedence over a reload and a decrement in the same cycle.
- R3: Control bits [31:18], [14:12] and [6:4] always read back as zero on `ctrl_rd`, whatever was written.
- R4: With control bit 7 = 0, the count source is `res_single[ctrl[3:0]]`. Each cycle that this source is high lowers the count by one on the next edge. Other lines have no effect.
- R5: With control bit 7 = 1, the count source is `res_pair[ctrl[2:0]]`. Bit 3 is ignored, and single lines have no effect.
- R6: Control bit 15 chooses the reload source type in the same way. Bit 15 = 0 selects `res_single[ctrl[11:8]]`, and bit 15 = 1 selects `res_pair[ctrl[10:8]]`. When the source is high, the count takes the reload value on the next edge.
- R7: With control bit 16 = 1, a cycle in which the count is zero and the count source is high reloads the counter. With bit 16 = 0, such a cycle leaves the count at zero.
- R8: With control bit 17 = 1, a high `chain_in` lowers the count by one. If it coincides with the count source, the count still drops by only one. With bit 17 = 0, `chain_in` has no effect.
- R9: A decrement at a count of zero leaves the count at zero. The count never wraps.
- R10: If a reload and a decrement fall in the same cycle, the count takes the reload value.
- R11: Every reload raises `reload_pulse` for the single cycle in which the reloaded value first appears on `count`. A count write raises no pulse.
- R12: `at_zero` is 1 exactly when `count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_single | input | 16 | Single event resource lines |
| res_pair | input | 8 | Combined resource-pair lines |
| chain_in | input | 1 | Reload pulse from the neighbouring lower counter |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 reload value, 2 count, 3 none |
| wr_data | input | 32 | Write data |
| ctrl_rd | output | 32 | Control word readback, reserved bits zero |
| count | output | 16 | Current count |
| at_zero | output | 1 | Count is zero |
| reload_pulse | output | 1 | One-cycle pulse per reload, for chaining upward |

## Verification
The bench puts a reload and a decrement in the same cycle. A design that gives the decrement priority would show the reload value minus one, or the old count minus one. It also drives `chain_in` together with the count source. A design that adds the two would drop the count by two. Counting down at zero with self-reload off checks for wrap: an error here would show 0xFFFF or a stray pulse. With self-reload on, the bench checks that the counter reloads only from zero and never early at one. Pair selects are driven with bit 3 (count field) or bit 11 (reload field) set, to catch a design that decodes the unused bit. A design that treats a count write as a reload would emit a pulse or lose the written value.

// File: rtl/evc_pkg.sv
package evc_pkg;
    localparam int CTRL_W     = 32;
    localparam int N_SINGLE   = 16;
    localparam int N_PAIR     = 8;
    localparam int SEL_W      = $clog2(N_SINGLE);
    localparam int PAIR_SEL_W = $clog2(N_PAIR);

    // writable control bits; all others read as zero
    localparam logic [CTRL_W-1:0] CTRL_MASK = 32'h0003_8F8F;

    typedef enum logic [1:0] {
        WSEL_CTRL   = 2'd0,
        WSEL_RELOAD = 2'd1,
        WSEL_COUNT  = 2'd2,
        WSEL_NONE   = 2'd3
    } wsel_e;

    typedef struct packed {
        logic             chain_en;
        logic             self_rld;
        logic             rld_pair;
        logic [SEL_W-1:0] rld_sel;
        logic             dec_pair;
        logic [SEL_W-1:0] dec_sel;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] w);
        ctrl_t c;
        c.chain_en = w[17];
        c.self_rld = w[16];
        c.rld_pair = w[15];
        c.rld_sel  = w[11:8];
        c.dec_pair = w[7];
        c.dec_sel  = w[3:0];
        return c;
    endfunction
endpackage

// File: rtl/evc_src_mux.sv
module evc_src_mux
    import evc_pkg::*;
(
    input  logic [N_SINGLE-1:0] single_i,
    input  logic [N_PAIR-1:0]   pair_i,
    input  logic                use_pair,
    input  logic [SEL_W-1:0]    sel,
    output logic                hit
);
    logic [PAIR_SEL_W-1:0] pair_sel;
    logic                  sel_msb_unused;

    assign pair_sel       = sel[PAIR_SEL_W-1:0];
    assign sel_msb_unused = sel[SEL_W-1];

    always_comb begin
        if (use_pair) hit = pair_i[pair_sel] | (sel_msb_unused & 1'b0);
        else          hit = single_i[sel];
    end
endmodule

// File: rtl/evc_regs.sv
module evc_regs
    import evc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] ctrl_word,
    output logic [CNT_W-1:0]  reload_val
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_word  <= '0;
            reload_val <= '0;
        end else if (wr_en) begin
            unique case (wsel_e'(wr_sel))
                WSEL_CTRL:   ctrl_word  <= wr_data & CTRL_MASK;
                WSEL_RELOAD: reload_val <= wr_data[CNT_W-1:0];
                WSEL_COUNT, WSEL_NONE: ;
            endcase
        end
    end
endmodule

// File: rtl/evc_core.sv
module evc_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             rld_fire,
    input  logic             dec_fire,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count_q,
    output logic             at_zero,
    output logic             reload_pulse
);
    typedef enum logic {ST_ACTIVE, ST_EXPIRED} phase_e;

    phase_e           state_q, state_d;
    logic [CNT_W-1:0] cnt_d;
    logic             pulse_q;

    // next count: write > reload > saturating decrement
    always_comb begin
        if (load_en)                          cnt_d = load_val;
        else if (rld_fire)                    cnt_d = reload_val;
        else if (dec_fire && count_q != '0)   cnt_d = count_q - 1'b1;
        else                                  cnt_d = count_q;
    end

    // transitions: drain (ACTIVE->EXPIRED), rearm (EXPIRED->ACTIVE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE:  if (cnt_d == '0) state_d = ST_EXPIRED;
            ST_EXPIRED: if (cnt_d != '0) state_d = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EXPIRED;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= cnt_d;
        end
    end

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= rld_fire & ~load_en;
    end

    assign at_zero      = (state_q == ST_EXPIRED);
    assign reload_pulse = pulse_q;
endmodule

// File: rtl/event_down_counter.sv
module event_down_counter
    import evc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_SINGLE-1:0] res_single,
    input  logic [N_PAIR-1:0]   res_pair,
    input  logic                chain_in,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [CTRL_W-1:0]   wr_data,
    output logic [CTRL_W-1:0]   ctrl_rd,
    output logic [CNT_W-1:0]    count,
    output logic                at_zero,
    output logic                reload_pulse
);
    logic [CTRL_W-1:0] ctrl_word;
    logic [CNT_W-1:0]  reload_val;
    ctrl_t             cfg;
    logic              dec_res, rld_res;
    logic              dec_fire, rld_fire, cnt_wr;

    evc_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ctrl_word(ctrl_word), .reload_val(reload_val)
    );

    assign cfg = unpack_ctrl(ctrl_word);

    evc_src_mux u_dec_mux (
        .single_i(res_single), .pair_i(res_pair),
        .use_pair(cfg.dec_pair), .sel(cfg.dec_sel), .hit(dec_res)
    );

    evc_src_mux u_rld_mux (
        .single_i(res_single), .pair_i(res_pair),
        .use_pair(cfg.rld_pair), .sel(cfg.rld_sel), .hit(rld_res)
    );

    assign cnt_wr   = wr_en && (wsel_e'(wr_sel) == WSEL_COUNT);
    assign dec_fire = dec_res | (cfg.chain_en & chain_in);
    assign rld_fire = rld_res | (cfg.self_rld & dec_res & (count == '0));

    evc_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .load_en(cnt_wr), .load_val(wr_data[CNT_W-1:0]),
        .rld_fire(rld_fire), .dec_fire(dec_fire), .reload_val(reload_val),
        .count_q(count), .at_zero(at_zero), .reload_pulse(reload_pulse)
    );

    assign ctrl_rd = ctrl_word;
endmodule

// File: rtl/evc_checker.sv
module evc_checker
    import evc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CTRL_W-1:0] ctrl_rd,
    input logic [CNT_W-1:0]  count,
    input logic              at_zero,
    input logic              reload_pulse,
    input logic              rld_fire,
    input logic              cnt_wr,
    input logic [CNT_W-1:0]  reload_val
);
    // R3
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd & ~CTRL_MASK) == '0);

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && !rld_fire && count == '0) |=> count == '0);

    // R10
    reload_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rld_fire && !cnt_wr) |=> count == $past(reload_val));

    // R11
    pulse_follows_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rld_fire && !cnt_wr) |=> reload_pulse);

    // R8
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && !rld_fire) |=>
            (count == $past(count) || count == $past(count) - 1'b1));

    // R12
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_zero == (count == '0));
endmodule

bind event_down_counter evc_checker #(.CNT_W(CNT_W)) u_evc_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_rd(ctrl_rd), .count(count),
    .at_zero(at_zero), .reload_pulse(reload_pulse), .rld_fire(rld_fire),
    .cnt_wr(cnt_wr), .reload_val(reload_val)
);

// File: tb/test_event_down_counter.sv
module test_event_down_counter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] res_single;
    logic [7:0]  res_pair;
    logic        chain_in;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic [31:0] ctrl_rd;
    logic [15:0] count;
    logic        at_zero;
    logic        reload_pulse;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    event_down_counter i_event_down_counter (
        .clk(clk), .rst_n(rst_n), .res_single(res_single), .res_pair(res_pair),
        .chain_in(chain_in), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ctrl_rd(ctrl_rd), .count(count), .at_zero(at_zero),
        .reload_pulse(reload_pulse)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        res_single = '0; res_pair = '0; chain_in = 1'b0;
        wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        tick();
        wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
    endtask

    task automatic t_reset();
        check("R1 count", {16'h0, count}, 32'h0);
        check("R1 ctrl", ctrl_rd, 32'h0);
        check("R1 at_zero", {31'h0, at_zero}, 32'h1);
        check("R1 pulse", {31'h0, reload_pulse}, 32'h0);
    endtask

    task automatic t_regs();
        wr(2'd0, 32'hFFFF_FFFF);
        check("R3 reserved bits", ctrl_rd, 32'h0003_8F8F);
        wr(2'd3, 32'h0000_1234);
        check("R2 sel 3 ignored", ctrl_rd, 32'h0003_8F8F);
        check("R2 sel 3 count", {16'h0, count}, 32'h0);
        wr(2'd0, 32'h0);
        check("R2 ctrl write", ctrl_rd, 32'h0);
    endtask

    task automatic t_dec_single();
        wr(2'd0, 32'h0000_0005);
        wr(2'd2, 32'd3);
        check("R2 count write", {16'h0, count}, 32'd3);
        res_single[5] = 1'b1; tick(); res_single[5] = 1'b0;
        check("R4 single decrement", {16'h0, count}, 32'd2);
        res_single[4] = 1'b1; tick(); res_single[4] = 1'b0;
        check("R4 other line ignored", {16'h0, count}, 32'd2);
        res_single[5] = 1'b1; tick(); tick(); res_single[5] = 1'b0;
        check("R4 reach zero", {16'h0, count}, 32'd0);
        check("R12 at_zero set", {31'h0, at_zero}, 32'h1);
        res_single[5] = 1'b1; tick(); res_single[5] = 1'b0;
        check("R9 saturate", {16'h0, count}, 32'd0);
        check("R7 no self reload", {31'h0, reload_pulse}, 32'h0);
    endtask

    task automatic t_dec_pair();
        wr(2'd0, 32'h0000_008B);
        wr(2'd2, 32'd5);
        check("R12 at_zero clear", {31'h0, at_zero}, 32'h0);
        res_pair[3] = 1'b1; tick(); res_pair[3] = 1'b0;
        check("R5 pair decrement", {16'h0, count}, 32'd4);
        res_single[11] = 1'b1; res_pair[2] = 1'b1; tick(); idle();
        check("R5 others ignored", {16'h0, count}, 32'd4);
    endtask

    task automatic t_reload_single();
        wr(2'd0, 32'h0000_0901);
        wr(2'd1, 32'hABCD_1234);
        wr(2'd2, 32'd7);
        res_single[9] = 1'b1; tick(); res_single[9] = 1'b0;
        check("R6 single reload", {16'h0, count}, 32'h1234);
        check("R11 pulse high", {31'h0, reload_pulse}, 32'h1);
        tick();
        check("R11 pulse one cycle", {31'h0, reload_pulse}, 32'h0);
        wr(2'd2, 32'h10);
        res_single[9] = 1'b1; res_single[1] = 1'b1; tick(); idle();
        check("R10 reload beats decrement", {16'h0, count}, 32'h1234);
    endtask

    task automatic t_reload_pair();
        wr(2'd0, 32'h0000_EE00);
        wr(2'd1, 32'h0000_00AA);
        wr(2'd2, 32'd2);
        res_single[14] = 1'b1; tick(); res_single[14] = 1'b0;
        check("R6 single ignored in pair mode", {16'h0, count}, 32'd2);
        res_pair[6] = 1'b1; tick(); res_pair[6] = 1'b0;
        check("R6 pair reload", {16'h0, count}, 32'hAA);
    endtask

    task automatic t_self_reload();
        wr(2'd0, 32'h0001_0002);
        wr(2'd1, 32'd3);
        wr(2'd2, 32'd1);
        res_single[2] = 1'b1; tick(); res_single[2] = 1'b0;
        check("R7 no early reload", {16'h0, count}, 32'd0);
        check("R7 no early pulse", {31'h0, reload_pulse}, 32'h0);
        res_single[2] = 1'b1; tick(); res_single[2] = 1'b0;
        check("R7 self reload", {16'h0, count}, 32'd3);
        check("R11 self reload pulse", {31'h0, reload_pulse}, 32'h1);
        wr(2'd0, 32'h0000_0002);
        wr(2'd2, 32'd0);
        res_single[2] = 1'b1; tick(); res_single[2] = 1'b0;
        check("R7 off stays zero", {16'h0, count}, 32'd0);
    endtask

    task automatic t_chain();
        wr(2'd0, 32'h0002_0004);
        wr(2'd2, 32'd10);
        chain_in = 1'b1; tick(); chain_in = 1'b0;
        check("R8 chain decrement", {16'h0, count}, 32'd9);
        chain_in = 1'b1; res_single[4] = 1'b1; tick(); idle();
        check("R8 coincident single step", {16'h0, count}, 32'd8);
        res_single[4] = 1'b1; tick(); res_single[4] = 1'b0;
        check("R8 own source", {16'h0, count}, 32'd7);
        wr(2'd0, 32'h0000_0004);
        chain_in = 1'b1; tick(); chain_in = 1'b0;
        check("R8 chain disabled", {16'h0, count}, 32'd7);
    endtask

    task automatic t_write_priority();
        wr(2'd0, 32'h0000_0900);
        wr(2'd1, 32'h50);
        res_single[9] = 1'b1;
        wr(2'd2, 32'h22);
        res_single[9] = 1'b0;
        check("R2 write beats reload", {16'h0, count}, 32'h22);
        check("R11 no pulse on write", {31'h0, reload_pulse}, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_regs();
        t_dec_single();
        t_dec_pair();
        t_reload_single();
        t_reload_pair();
        t_self_reload();
        t_chain();
        t_write_priority();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule